// File: doc/BRIEF.md
# LED Driver Fault Supervisor

This block is the digital protection manager of a switching LED driver. It takes the flags from the analog comparators (supply undervoltage, over-temperature, output overvoltage, switch overcurrent, feedback-low, overvoltage warning, LED short), the enable input, the state of the PWM dimming output and a tick at the switching frequency. From these it produces a switching enable, a soft-start discharge request, a global shutdown and two active-low fault flags. The comparators, the soft-start ramp, the gate drivers and the PWM generator sit outside the block.

There are two kinds of protection. Undervoltage, over-temperature, overvoltage and overcurrent recover by themselves once the condition is gone. A ground short, an open LED and a shorted LED latch the driver off until enable is taken low or an undervoltage occurs. The ground-short and LED-short faults only latch after their condition has held for a full timer window. The ground-short window is a cycle count taken from a register input, which stands in for an external timing capacitor. After enable rises, a start-up timer resets the ground-short timer and the soft start each time its window runs out before the first PWM-on. This keeps a late dimming input from being mistaken for a short.

Every comparator input passes through a two-flop synchronizer. All five outputs are registered.

Top module: `led_fault_supervisor`

## Requirements
- R1: After reset, or while enable is low: shutdown=1, sw_enable=0, ss_discharge=0, fault1_n=1 and fault2_n=1.
- R2: Undervoltage or over-temperature drives shutdown high and fault1_n low. Both return to normal by themselves when the condition clears.
- R3: Overvoltage or overcurrent drives ss_discharge high and sw_enable low, with shutdown kept low. Overvoltage also pulls fault1_n low and overcurrent does not. Operation resumes when the condition clears.
- R4: ss_discharge is never high while shutdown is high. Shutdown takes precedence, and fault1_n still reports every active cause.
- R5: Feedback-low held for gs_limit consecutive cycles while running latches a ground short: shutdown=1 and fault1_n=0. A shorter episode resets the count and has no effect.
- R6: Feedback-low together with the overvoltage warning latches an open LED on the next cycle, with no timer: shutdown=1 and fault2_n=0.
- R7: An LED short latches (shutdown=1, fault2_n=0) after SHORT_TICKS switching ticks counted while the PWM output is high. The count holds while PWM is low and resets when the short clears.
- R8: Latched faults persist after their condition is gone. Only enable low or undervoltage clears them.
- R9: From an enable rise until the first PWM-on, each window of PLT_TICKS ticks ends in a one-cycle ss_discharge pulse and a reset of the ground-short timer, so feedback-low cannot latch a ground short in that phase.
- R10: sw_enable is high only when shutdown and ss_discharge are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_tick | input | 1 | One-cycle strobe per switching period |
| en_in | input | 1 | Enable (asynchronous) |
| uv_in | input | 1 | Supply undervoltage comparator |
| ot_in | input | 1 | Over-temperature comparator |
| ov_in | input | 1 | Output overvoltage comparator |
| oc_in | input | 1 | Switch overcurrent comparator |
| fb_low_in | input | 1 | Feedback voltage below short threshold |
| ov_warn_in | input | 1 | Output above the open-LED warning level |
| led_short_in | input | 1 | LED string short comparator |
| pwm_in | input | 1 | PWM dimming output state |
| gs_limit | input | GS_W | Ground-short timeout in clock cycles |
| ss_discharge | output | 1 | Request to discharge the soft-start ramp |
| sw_enable | output | 1 | Switching allowed |
| shutdown | output | 1 | Global shutdown of everything but the regulator |
| fault1_n | output | 1 | Active-low: undervoltage, over-temperature, overvoltage or ground short |
| fault2_n | output | 1 | Active-low: open or shorted LED |

## Verification
The assertions check on every cycle that shutdown wins over soft-start discharge, that switching is never enabled alongside either one, that a synchronized undervoltage reaches shutdown one cycle later, that overvoltage pulls fault1_n low, and that the open-LED latch sets on the cycle after its condition. Timer-based behaviour needs the bench's scenarios. These include how long each timeout lasts, the count resetting on a short episode, the LED-short count holding while PWM is low, the start-up timer holding off a ground short until PWM starts, and latches surviving until enable low or undervoltage.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;

    // Synchronized comparator and control flags
    typedef struct packed {
        logic en;
        logic uv;
        logic ot;
        logic ov;
        logic oc;
        logic fbl;
        logic ovw;
        logic lshort;
        logic pwm;
    } cmp_t;

    localparam int NCMP = $bits(cmp_t);

    // Latched protection state
    typedef struct packed {
        logic gnd;
        logic open;
        logic lshort;
    } latch_t;

    // Registered output bundle
    typedef struct packed {
        logic shutdown;
        logic ss_dis;
        logic sw_en;
        logic flt1_n;
        logic flt2_n;
    } out_t;

    localparam out_t OUT_RESET = '{shutdown: 1'b1, ss_dis: 1'b0, sw_en: 1'b0,
                                   flt1_n: 1'b1, flt2_n: 1'b1};

    function automatic logic any_latched(latch_t l);
        return l.gnd | l.open | l.lshort;
    endfunction

    function automatic logic latch_release(cmp_t c);
        return ~c.en | c.uv;
    endfunction

    function automatic logic group1_fault(cmp_t c, latch_t l);
        return c.uv | c.ot | c.ov | l.gnd;
    endfunction

    function automatic logic group2_fault(latch_t l);
        return l.open | l.lshort;
    endfunction

endpackage

// File: rtl/lfs_sync.sv
module lfs_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/lfs_timer.sv
module lfs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv && !done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lfs_core.sv
module lfs_core
    import led_fault_pkg::*;
#(
    parameter int GS_W        = 20,
    parameter int SHORT_TICKS = 32770,
    parameter int PLT_TICKS   = 32770
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  cmp_t            c,
    input  logic [GS_W-1:0] gs_limit,
    output out_t            o,
    output latch_t          lat_q
);
    localparam int SW = $clog2(SHORT_TICKS + 1);
    localparam int PW = $clog2(PLT_TICKS + 1);

    logic   run;
    logic   pwm_seen, armed;
    logic   plt_done, plt_fire;
    logic   gs_done, sh_done;
    logic   shut_c, ss_c;
    latch_t lat_set, lat_d;
    out_t   o_d;

    assign run = c.en & ~c.uv & ~c.ot;

    // Start-up phase: armed from enable until the first PWM-on
    always_ff @(posedge clk) begin
        if (rst || !c.en)
            pwm_seen <= 1'b0;
        else if (c.pwm)
            pwm_seen <= 1'b1;
    end
    assign armed    = c.en & ~pwm_seen;
    assign plt_fire = plt_done & armed;

    lfs_timer #(.W(PW)) plt_tmr_i (
        .clk(clk), .rst(rst),
        .clr(~armed | plt_done),
        .adv(tick & armed),
        .limit(PW'(PLT_TICKS)),
        .done(plt_done)
    );

    // Ground-short window counts clock cycles
    lfs_timer #(.W(GS_W)) gs_tmr_i (
        .clk(clk), .rst(rst),
        .clr(~(c.fbl & run) | plt_fire),
        .adv(1'b1),
        .limit(gs_limit),
        .done(gs_done)
    );

    // LED-short window counts switching ticks while PWM is high
    lfs_timer #(.W(SW)) sh_tmr_i (
        .clk(clk), .rst(rst),
        .clr(~(c.lshort & run)),
        .adv(tick & c.pwm),
        .limit(SW'(SHORT_TICKS)),
        .done(sh_done)
    );

    always_comb begin
        lat_set.gnd    = run & c.fbl & gs_done & ~plt_fire;
        lat_set.open   = run & c.fbl & c.ovw;
        lat_set.lshort = run & c.lshort & sh_done;
        if (latch_release(c))
            lat_d = '0;
        else
            lat_d = lat_q | lat_set;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else
            lat_q <= lat_d;
    end

    always_comb begin
        shut_c     = ~run | any_latched(lat_q);
        ss_c       = ~shut_c & (c.ov | c.oc | plt_fire);
        o_d.shutdown = shut_c;
        o_d.ss_dis   = ss_c;
        o_d.sw_en    = ~shut_c & ~ss_c;
        o_d.flt1_n   = ~group1_fault(c, lat_q);
        o_d.flt2_n   = ~group2_fault(lat_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            o <= OUT_RESET;
        else
            o <= o_d;
    end
endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor
    import led_fault_pkg::*;
#(
    parameter int GS_W        = 20,
    parameter int SHORT_TICKS = 32770,
    parameter int PLT_TICKS   = 32770
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_tick,
    input  logic            en_in,
    input  logic            uv_in,
    input  logic            ot_in,
    input  logic            ov_in,
    input  logic            oc_in,
    input  logic            fb_low_in,
    input  logic            ov_warn_in,
    input  logic            led_short_in,
    input  logic            pwm_in,
    input  logic [GS_W-1:0] gs_limit,
    output logic            ss_discharge,
    output logic            sw_enable,
    output logic            shutdown,
    output logic            fault1_n,
    output logic            fault2_n
);
    cmp_t   cmp_raw, cmp_s;
    latch_t lat_q;
    out_t   o;

    assign cmp_raw = '{en: en_in, uv: uv_in, ot: ot_in, ov: ov_in, oc: oc_in,
                       fbl: fb_low_in, ovw: ov_warn_in, lshort: led_short_in,
                       pwm: pwm_in};

    lfs_sync #(.N(NCMP)) sync_i (
        .clk(clk), .rst(rst), .d(cmp_raw), .q(cmp_s)
    );

    lfs_core #(
        .GS_W(GS_W), .SHORT_TICKS(SHORT_TICKS), .PLT_TICKS(PLT_TICKS)
    ) core_i (
        .clk(clk), .rst(rst), .tick(sw_tick), .c(cmp_s),
        .gs_limit(gs_limit), .o(o), .lat_q(lat_q)
    );

    assign shutdown     = o.shutdown;
    assign ss_discharge = o.ss_dis;
    assign sw_enable    = o.sw_en;
    assign fault1_n     = o.flt1_n;
    assign fault2_n     = o.flt2_n;
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker
    import led_fault_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input cmp_t   s,
    input latch_t lat,
    input logic   shutdown,
    input logic   ss_discharge,
    input logic   sw_enable,
    input logic   fault1_n,
    input logic   fault2_n
);
    // R4
    shutdown_over_ssdis_chk: assert property (@(posedge clk) disable iff (rst)
        !(shutdown && ss_discharge));

    // R10
    swen_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        sw_enable |-> (!shutdown && !ss_discharge));

    // R2
    uv_to_shutdown_chk: assert property (@(posedge clk) disable iff (rst)
        s.uv |=> shutdown);

    // R3
    ov_flag1_chk: assert property (@(posedge clk) disable iff (rst)
        s.ov |=> !fault1_n);

    // R6
    open_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (s.fbl && s.ovw && s.en && !s.uv && !s.ot) |=> lat.open);

    // R8
    flag2_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fault2_n && s.en && !s.uv) |=> !fault2_n);
endmodule

bind led_fault_supervisor lfs_checker chk_i (
    .clk(clk), .rst(rst), .s(cmp_s), .lat(lat_q),
    .shutdown(shutdown), .ss_discharge(ss_discharge), .sw_enable(sw_enable),
    .fault1_n(fault1_n), .fault2_n(fault2_n)
);

// File: tb/led_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module led_fault_supervisor_tb_top;
    localparam int GS_W = 16;
    localparam int SHORT_T = 20;
    localparam int PLT_T = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic en = 0, uv = 0, ot = 0, ov = 0, oc = 0, fbl = 0, ovw = 0, lsh = 0, pwm = 0;
    logic [GS_W-1:0] gs_limit = 16'd30;
    logic ss_discharge, sw_enable, shutdown, fault1_n, fault2_n;

    always #5 clk = ~clk;

    led_fault_supervisor #(.GS_W(GS_W), .SHORT_TICKS(SHORT_T), .PLT_TICKS(PLT_T)) dut_i (
        .clk(clk), .rst(rst), .sw_tick(tick), .en_in(en), .uv_in(uv), .ot_in(ot),
        .ov_in(ov), .oc_in(oc), .fb_low_in(fbl), .ov_warn_in(ovw),
        .led_short_in(lsh), .pwm_in(pwm), .gs_limit(gs_limit),
        .ss_discharge(ss_discharge), .sw_enable(sw_enable), .shutdown(shutdown),
        .fault1_n(fault1_n), .fault2_n(fault2_n)
    );

    typedef struct {
        string      req;
        logic [4:0] exp;
        logic [4:0] mask;
    } item_t;

    item_t exp_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    bit pulse_win = 0;
    int pulses = 0;

    // Monitor: order shutdown, ss_discharge, sw_enable, fault1_n, fault2_n
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [4:0] got;
            it  = exp_q.pop_front();
            got = {shutdown, ss_discharge, sw_enable, fault1_n, fault2_n};
            n_checks++;
            if (((got ^ it.exp) & it.mask) != 5'b0) begin
                n_fails++;
                $display("FAIL %s: actual sd/ss/sw/f1/f2=%b expected %b (mask %b)",
                         it.req, got, it.exp, it.mask);
            end
        end
    end

    always @(posedge clk)
        if (pulse_win && ss_discharge) pulses++;

    task automatic settle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_o(string r, logic sd, logic ss, logic sw, logic f1, logic f2,
                            logic [4:0] m = 5'b11111);
        item_t it;
        it.req = r; it.exp = {sd, ss, sw, f1, f2}; it.mask = m;
        exp_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic note(bit ok, string r, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    localparam logic [4:0] M_SD_F = 5'b10011;

    initial begin
        settle(3);
        rst = 0;
        settle(2);
        expect_o("R1 reset state", 1, 0, 0, 1, 1);

        en = 1; pwm = 1; settle(8);
        expect_o("R10 normal run", 0, 0, 1, 1, 1);

        uv = 1; settle(8);
        expect_o("R2 undervoltage", 1, 0, 0, 0, 1);
        uv = 0; settle(8);
        expect_o("R2 uv recovery", 0, 0, 1, 1, 1);

        ot = 1; settle(8);
        expect_o("R2 over-temperature", 1, 0, 0, 0, 1);
        ot = 0; settle(8);
        expect_o("R2 ot recovery", 0, 0, 1, 1, 1);

        ov = 1; settle(8);
        expect_o("R3 overvoltage", 0, 1, 0, 0, 1);
        ov = 0; settle(8);
        expect_o("R3 ov recovery", 0, 0, 1, 1, 1);

        oc = 1; settle(8);
        expect_o("R3 overcurrent", 0, 1, 0, 1, 1);
        oc = 0; settle(8);

        ov = 1; ot = 1; settle(8);
        expect_o("R4 shutdown over discharge", 1, 0, 0, 0, 1);
        ov = 0; ot = 0; settle(8);
        expect_o("R4 recovery", 0, 0, 1, 1, 1);

        // Ground short window, limit 30
        fbl = 1; settle(20); fbl = 0; settle(8);
        expect_o("R5 short episode ignored", 0, 0, 1, 1, 1);
        fbl = 1; settle(45);
        expect_o("R5 ground short latched", 1, 0, 0, 0, 1);
        fbl = 0; settle(20);
        expect_o("R8 ground short persists", 1, 0, 0, 0, 1);
        en = 0; settle(8);
        expect_o("R1 enable low", 1, 0, 0, 1, 1);
        en = 1; settle(8);
        expect_o("R8 cleared by enable low", 0, 0, 1, 1, 1);

        // Open LED
        fbl = 1; ovw = 1; settle(6);
        expect_o("R6 open latched", 1, 0, 0, 1, 0);
        fbl = 0; ovw = 0; settle(10);
        expect_o("R8 open persists", 1, 0, 0, 1, 0);
        uv = 1; settle(8);
        expect_o("R2 uv during latch", 1, 0, 0, 0, 1);
        uv = 0; settle(8);
        expect_o("R8 cleared by undervoltage", 0, 0, 1, 1, 1);

        // LED short, 20 ticks
        lsh = 1; settle(12); lsh = 0; settle(8);
        expect_o("R7 short cleared early", 0, 0, 1, 1, 1);
        pwm = 0; lsh = 1; settle(50);
        expect_o("R7 pwm low holds count", 0, 0, 1, 1, 1);
        pwm = 1; settle(30);
        expect_o("R7 led short latched", 1, 0, 0, 1, 0);
        lsh = 0; en = 0; pwm = 0; settle(8);
        expect_o("R8 enable low clears short", 1, 0, 0, 1, 1);

        // Start-up timer: no PWM yet, feedback low, gs limit 60
        gs_limit = 16'd60;
        en = 1; fbl = 1; pulse_win = 1; settle(150);
        pulse_win = 0;
        expect_o("R9 start-up holds off ground short", 0, 0, 0, 1, 1, M_SD_F);
        note(pulses >= 2, "R9 discharge pulses", pulses, 2);
        pwm = 1; settle(80);
        expect_o("R9 ground short after pwm on", 1, 0, 0, 0, 1);
        fbl = 0; en = 0; settle(8);
        expect_o("R1 final disable", 1, 0, 0, 1, 1);

        settle(2);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule